// File: doc/BRIEF.md
# E1 PCM Highway Serial Port

This block connects a local PCM highway running at 2048 kbit/s to internal byte streams. On the outbound path, internal logic places one byte per time slot into a slot buffer. The port then serializes those bytes onto a serial data output that can be put in high impedance. On the inbound path, the port collects bits from a serial data input and hands each finished byte to internal logic. Each byte comes with its slot index and a one-cycle strobe. A frame has 32 slots of 8 bits each, 256 bit positions in all.

Both directions run from a single local bit clock, which is the block clock. A clock-enable divider sets the data rate to one bit per 1, 2, 4 or 8 local clock cycles. This keeps the highway at 2048 kbit/s whether the local clock runs at 2048, 4096, 8192 or 16384 kHz. The outbound and inbound directions each have their own frame-sync input. A frame-sync pulse may arrive every frame or only every N frames; between pulses, the position counters free-run. A configuration write sets the clock ratio and whether slot 0 is carried. The output stays disabled until the first configuration write.

Top module: `pcm_hwy_port`

## Requirements
- R1: After reset, `dout_oe` is 0 and stays 0 until the first clock edge with `cfg_wr` high. After that write, `dout_oe` is 1 in every slot except where R4 says otherwise.
- R2: `dout` changes only on rising clock edges at bit boundaries. Slot n carries the byte last written with `ob_wr`/`ob_slot`=n at an edge strictly before the edge that starts bit 0 of slot n. The byte is sent MSB first.
- R3: `din` is sampled on falling clock edges; the sample taken last before a bit period ends is the one used. One edge after the last bit of a slot, `ib_valid` pulses for one cycle. With it, `ib_data` holds the byte (first bit received as MSB) and `ib_slot` holds the slot index.
- R4: With `cfg_ts0`=0, slot 0 is not carried: `dout_oe` is 0 throughout slot 0 and no `ib_valid` is produced for slot 0. With `cfg_ts0`=1, slot 0 is carried like any other slot. Reset value: 0.
- R5: `cfg_rate` code k (0 to 3) makes each bit last 2^k clock cycles in both directions. Reset value: 0.
- R6: `ob_fs` high at a rising edge makes that edge the start of bit 0 of slot 0 on `dout`. Between pulses, the outbound bit position wraps modulo 256.
- R7: `ib_fs` high at a rising edge makes that edge the start of bit 0 of slot 0 on `din`. A byte that completes at that same edge is still delivered. Between pulses, the inbound bit position wraps modulo 256.
- R8: `ib_odd` is 0 for bytes of the frame started by an `ib_fs` pulse. It toggles at each free-running inbound wrap, so with a sync every second frame it alternates 0,1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bit clock; rising edges launch output bits, falling edges sample input bits |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rate | input | 2 | Clock cycles per bit code: 2^code |
| cfg_ts0 | input | 1 | 1 = slot 0 carried, 0 = slot 0 skipped |
| ob_fs | input | 1 | Outbound frame start pulse |
| ob_wr | input | 1 | Outbound slot buffer write |
| ob_slot | input | 5 | Slot index of the outbound write |
| ob_data | input | 8 | Outbound byte |
| dout | output | 1 | Serial highway data out |
| dout_oe | output | 1 | Output enable for the `dout` pad driver |
| ib_fs | input | 1 | Inbound frame start pulse |
| din | input | 1 | Serial highway data in |
| ib_valid | output | 1 | One-cycle strobe for a completed inbound byte |
| ib_slot | output | 5 | Slot index of the inbound byte |
| ib_data | output | 8 | Inbound byte |
| ib_odd | output | 1 | Frame parity of the inbound byte |

## Verification
The assertions assume three things about the inputs. `ob_fs` and `ib_fs` are single-cycle pulses. Configuration writes happen only at whole-cycle boundaries. `din` is stable around each falling edge. The bench drives every input one nanosecond after a rising edge, so falling-edge samples are always clean. It holds each sync pulse for exactly one cycle. It issues configuration writes and sync pulses at arbitrary positions, including mid-frame, to exercise realignment. It also changes `din` every clock at the divided rates, so only the designated falling edge can decide the captured bit.

// File: rtl/pcm_hwy_pkg.sv
package pcm_hwy_pkg;

   // clock cycles per highway bit: 2^code
   typedef enum logic [1:0] {
      PCM_RATE_X1 = 2'd0,
      PCM_RATE_X2 = 2'd1,
      PCM_RATE_X4 = 2'd2,
      PCM_RATE_X8 = 2'd3
   } pcm_rate_e;

   typedef struct packed {
      logic      done;
      logic      ts0_on;
      pcm_rate_e rate;
   } pcm_cfg_t;

endpackage

// File: rtl/pcm_hwy_timer.sv
// Bit-rate divider plus bit/slot position counter for one highway direction.
module pcm_hwy_timer #(
   parameter int SLOT_W   = 5,
   parameter int BIT_W    = 3,
   parameter int MAX_RATE = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fs,
   input  logic [1:0]        rate,
   output logic [SLOT_W-1:0] slot,
   output logic              last_bit,
   output logic              bit_end,
   output logic              slot_load,
   output logic [SLOT_W-1:0] nxt_slot,
   output logic              wrap
);

   localparam int POS_W = SLOT_W + BIT_W;

   logic [POS_W-1:0] pos_q;

   generate
      if (MAX_RATE == 0) begin : g_nodiv
         logic unused_rate;
         assign unused_rate = &{1'b0, rate};
         assign bit_end = 1'b1;
      end else begin : g_div
         logic [MAX_RATE-1:0] div_q;
         logic [MAX_RATE-1:0] lim;
         int                  eff;
         always_comb begin
            eff = (int'(rate) > MAX_RATE) ? MAX_RATE : int'(rate);
            for (int k = 0; k < MAX_RATE; k++) begin
               lim[k] = (k < eff);
            end
         end
         assign bit_end = (div_q >= lim);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                div_q <= '0;
            else if (fs || bit_end)    div_q <= '0;
            else                       div_q <= div_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pos_q <= '0;
      else if (fs)      pos_q <= '0;
      else if (bit_end) pos_q <= pos_q + 1'b1;
   end

   assign slot      = pos_q[POS_W-1:BIT_W];
   assign last_bit  = &pos_q[BIT_W-1:0];
   assign wrap      = bit_end && (&pos_q);
   assign slot_load = fs || (bit_end && last_bit);
   assign nxt_slot  = fs ? '0 : slot + 1'b1;

endmodule

// File: rtl/pcm_hwy_out.sv
// Outbound slot buffer and MSB-first serializer.
module pcm_hwy_out #(
   parameter int SLOT_COUNT = 32,
   parameter int SLOT_WIDTH = 8,
   parameter int SLOT_W     = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr,
   input  logic [SLOT_W-1:0]     wr_slot,
   input  logic [SLOT_WIDTH-1:0] wr_data,
   input  logic                  load,
   input  logic [SLOT_W-1:0]     load_slot,
   input  logic                  shift,
   output logic                  sdo
);

   logic [SLOT_WIDTH-1:0] mem_q [SLOT_COUNT];
   logic [SLOT_WIDTH-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SLOT_COUNT; i++) mem_q[i] <= '0;
      end else if (wr) begin
         mem_q[wr_slot] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh_q <= '0;
      else if (load)  sh_q <= mem_q[load_slot];
      else if (shift) sh_q <= {sh_q[SLOT_WIDTH-2:0], 1'b0};
   end

   assign sdo = sh_q[SLOT_WIDTH-1];

endmodule

// File: rtl/pcm_hwy_in.sv
// Inbound falling-edge sampler, deserializer and frame parity.
module pcm_hwy_in #(
   parameter int SLOT_WIDTH = 8,
   parameter int SLOT_W     = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  din,
   input  logic                  fs,
   input  logic                  bit_end,
   input  logic                  last_bit,
   input  logic                  wrap,
   input  logic [SLOT_W-1:0]     slot,
   input  logic                  gate_off,
   output logic                  valid,
   output logic [SLOT_WIDTH-1:0] data,
   output logic [SLOT_W-1:0]     slot_o,
   output logic                  odd
);

   logic                  din_n;
   logic [SLOT_WIDTH-1:0] sh_q;
   logic                  odd_q;
   logic                  done;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) din_n <= 1'b0;
      else        din_n <= din;
   end

   assign done = bit_end && last_bit && !gate_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         valid  <= 1'b0;
         data   <= '0;
         slot_o <= '0;
         odd    <= 1'b0;
         odd_q  <= 1'b0;
      end else begin
         if (bit_end) sh_q <= {sh_q[SLOT_WIDTH-2:0], din_n};
         valid <= done;
         if (done) begin
            data   <= {sh_q[SLOT_WIDTH-2:0], din_n};
            slot_o <= slot;
            odd    <= odd_q;
         end
         if (fs)        odd_q <= 1'b0;
         else if (wrap) odd_q <= ~odd_q;
      end
   end

endmodule

// File: rtl/pcm_hwy_port.sv
module pcm_hwy_port
   import pcm_hwy_pkg::*;
#(
   parameter int SLOT_COUNT = 32,
   parameter int SLOT_WIDTH = 8,
   parameter int MAX_RATE   = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_wr,
   input  logic [1:0]                    cfg_rate,
   input  logic                          cfg_ts0,
   input  logic                          ob_fs,
   input  logic                          ob_wr,
   input  logic [$clog2(SLOT_COUNT)-1:0] ob_slot,
   input  logic [SLOT_WIDTH-1:0]         ob_data,
   output logic                          dout,
   output logic                          dout_oe,
   input  logic                          ib_fs,
   input  logic                          din,
   output logic                          ib_valid,
   output logic [$clog2(SLOT_COUNT)-1:0] ib_slot,
   output logic [SLOT_WIDTH-1:0]         ib_data,
   output logic                          ib_odd
);

   localparam int SLOT_W = $clog2(SLOT_COUNT);
   localparam int BIT_W  = $clog2(SLOT_WIDTH);

   generate
      if (SLOT_COUNT < 2 || (SLOT_COUNT & (SLOT_COUNT - 1)) != 0) begin : g_bad_count
         $error("SLOT_COUNT must be a power of two of at least 2");
      end
      if (SLOT_WIDTH < 2 || (SLOT_WIDTH & (SLOT_WIDTH - 1)) != 0) begin : g_bad_width
         $error("SLOT_WIDTH must be a power of two of at least 2");
      end
      if (MAX_RATE < 0 || MAX_RATE > 3) begin : g_bad_rate
         $error("MAX_RATE must lie in 0..3");
      end
   endgenerate

   pcm_cfg_t cfg_q;
   logic     cfg_done;
   logic     ts0_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '{done: 1'b0, ts0_on: 1'b0, rate: PCM_RATE_X1};
      else if (cfg_wr) cfg_q <= '{done: 1'b1, ts0_on: cfg_ts0, rate: pcm_rate_e'(cfg_rate)};
   end

   assign cfg_done = cfg_q.done;
   assign ts0_on   = cfg_q.ts0_on;

   // outbound direction
   logic [SLOT_W-1:0] ob_slot_idx, ob_nxt_slot;
   logic              ob_last, ob_bit_end, ob_load, ob_wrap;
   logic              ob_slot0;

   pcm_hwy_timer #(.SLOT_W(SLOT_W), .BIT_W(BIT_W), .MAX_RATE(MAX_RATE)) u_ob_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .fs       (ob_fs),
      .rate     (cfg_q.rate),
      .slot     (ob_slot_idx),
      .last_bit (ob_last),
      .bit_end  (ob_bit_end),
      .slot_load(ob_load),
      .nxt_slot (ob_nxt_slot),
      .wrap     (ob_wrap)
   );

   pcm_hwy_out #(.SLOT_COUNT(SLOT_COUNT), .SLOT_WIDTH(SLOT_WIDTH), .SLOT_W(SLOT_W)) u_ob_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (ob_wr),
      .wr_slot  (ob_slot),
      .wr_data  (ob_data),
      .load     (ob_load),
      .load_slot(ob_nxt_slot),
      .shift    (ob_bit_end),
      .sdo      (dout)
   );

   assign ob_slot0 = (ob_slot_idx == '0);
   assign dout_oe  = cfg_done && (ts0_on || !ob_slot0);

   // inbound direction
   logic [SLOT_W-1:0] ib_slot_idx, ib_nxt_slot;
   logic              ib_last, ib_bit_end, ib_load, ib_wrap;
   logic              ib_gate;

   pcm_hwy_timer #(.SLOT_W(SLOT_W), .BIT_W(BIT_W), .MAX_RATE(MAX_RATE)) u_ib_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .fs       (ib_fs),
      .rate     (cfg_q.rate),
      .slot     (ib_slot_idx),
      .last_bit (ib_last),
      .bit_end  (ib_bit_end),
      .slot_load(ib_load),
      .nxt_slot (ib_nxt_slot),
      .wrap     (ib_wrap)
   );

   assign ib_gate = !ts0_on && (ib_slot_idx == '0);

   pcm_hwy_in #(.SLOT_WIDTH(SLOT_WIDTH), .SLOT_W(SLOT_W)) u_ib_des (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (din),
      .fs      (ib_fs),
      .bit_end (ib_bit_end),
      .last_bit(ib_last),
      .wrap    (ib_wrap),
      .slot    (ib_slot_idx),
      .gate_off(ib_gate),
      .valid   (ib_valid),
      .data    (ib_data),
      .slot_o  (ib_slot),
      .odd     (ib_odd)
   );

   logic unused_timer;
   assign unused_timer = &{1'b0, ob_last, ob_wrap, ib_load, ib_nxt_slot};

endmodule

// File: rtl/pcm_hwy_port_chk.sv
module pcm_hwy_port_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_done,
   input logic ts0_on,
   input logic ob_fs,
   input logic ob_bit_end,
   input logic ob_slot0,
   input logic dout,
   input logic dout_oe,
   input logic ib_valid,
   input logic ib_slot0
);

   a_r1_off_before_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_done |-> !dout_oe);

   a_r1_cfg_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |=> cfg_done);

   a_r2_dout_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!ob_bit_end && !ob_fs) |=> $stable(dout));

   a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      ib_valid |=> !ib_valid);

   a_r4_no_slot0_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (ib_valid && !$past(ts0_on)) |-> !ib_slot0);

   a_r6_sync_to_slot0: assert property (@(posedge clk) disable iff (!rst_n)
      ob_fs |=> ob_slot0);

endmodule

bind pcm_hwy_port pcm_hwy_port_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_done  (cfg_done),
   .ts0_on    (ts0_on),
   .ob_fs     (ob_fs),
   .ob_bit_end(ob_bit_end),
   .ob_slot0  (ob_slot0),
   .dout      (dout),
   .dout_oe   (dout_oe),
   .ib_valid  (ib_valid),
   .ib_slot0  (ib_slot == '0)
);

// File: tb/pcm_hwy_port_tb.sv
module pcm_hwy_port_tb;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0, cfg_ts0 = 1'b0;
   logic [1:0] cfg_rate = 2'd0;
   logic       ob_fs = 1'b0, ob_wr = 1'b0;
   logic [4:0] ob_slot = '0;
   logic [7:0] ob_data = '0;
   logic       ib_fs = 1'b0, din = 1'b0;
   logic       dout, dout_oe, ib_valid, ib_odd;
   logic [4:0] ib_slot;
   logic [7:0] ib_data;

   pcm_hwy_port u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rate(cfg_rate), .cfg_ts0(cfg_ts0),
      .ob_fs(ob_fs), .ob_wr(ob_wr), .ob_slot(ob_slot), .ob_data(ob_data),
      .dout(dout), .dout_oe(dout_oe), .ib_fs(ib_fs), .din(din),
      .ib_valid(ib_valid), .ib_slot(ib_slot), .ib_data(ib_data), .ib_odd(ib_odd)
   );

   int    checks = 0, errors = 0;
   string tag = "R1";
   bit    run_cmp = 1'b0;
   int    odd_seen = 0, even_seen = 0;

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // behavioural reference
   logic [7:0] obuf [32];
   logic [7:0] ocur, ish;
   int  cfg_done_m, rate_m, ts0_m;
   int  ob_pos, ob_div, ib_pos, ib_div, ib_odd_m;
   logic din_n_m;
   logic e_oe, e_dout, e_v, e_odd;
   logic [4:0] e_slot;
   logic [7:0] e_data;

   always @(negedge clk) din_n_m = din;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (obuf[i]) obuf[i] = 8'h00;
         ocur = 0; ish = 0; cfg_done_m = 0; rate_m = 0; ts0_m = 0;
         ob_pos = 0; ob_div = 0; ib_pos = 0; ib_div = 0; ib_odd_m = 0;
         e_oe = 0; e_dout = 0; e_v = 0; e_odd = 0; e_slot = 0; e_data = 0;
      end else begin
         int ratio;
         bit fin;
         ratio = 1 << rate_m;
         // outbound
         fin = (ob_div >= ratio - 1);
         if (ob_fs) begin
            ob_pos = 0; ob_div = 0; ocur = obuf[0];
         end else if (fin) begin
            ob_pos = (ob_pos + 1) % 256; ob_div = 0;
            if (ob_pos % 8 == 0) ocur = obuf[ob_pos / 8];
         end else ob_div++;
         if (ob_wr) obuf[ob_slot] = ob_data;
         // inbound
         fin = (ib_div >= ratio - 1);
         e_v = 0;
         if (fin) begin
            ish = {ish[6:0], din_n_m};
            if (ib_pos % 8 == 7 && (ts0_m != 0 || ib_pos / 8 != 0)) begin
               e_v = 1; e_data = ish; e_slot = 5'(ib_pos / 8); e_odd = ib_odd_m[0];
            end
         end
         if (ib_fs) begin
            ib_pos = 0; ib_div = 0; ib_odd_m = 0;
         end else if (fin) begin
            if (ib_pos == 255) ib_odd_m ^= 1;
            ib_pos = (ib_pos + 1) % 256; ib_div = 0;
         end else ib_div++;
         // configuration
         if (cfg_wr) begin cfg_done_m = 1; rate_m = cfg_rate; ts0_m = cfg_ts0; end
         e_oe   = (cfg_done_m != 0) && (ts0_m != 0 || ob_pos / 8 != 0);
         e_dout = ocur[7 - ob_pos % 8];
      end
   end

   always @(posedge clk) begin
      #2;
      if (run_cmp) begin
         chk("R1 R4 dout_oe", dout_oe, e_oe);
         if (e_oe) chk("R2 dout", dout, e_dout);
         chk("R3 R4 ib_valid", ib_valid, e_v);
         if (e_v) begin
            chk("R3 ib_data", ib_data, e_data);
            chk("R3 ib_slot", ib_slot, e_slot);
            chk("R8 ib_odd", ib_odd, e_odd);
            if (ib_odd) odd_seen++; else even_seen++;
         end
      end
   end

   logic [15:0] lfsr = 16'hACE1;

   task automatic step();
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      din   = lfsr[0];
      ob_fs = 1'b0; ib_fs = 1'b0; ob_wr = 1'b0; cfg_wr = 1'b0;
   endtask

   task automatic configure(int rate, bit ts0);
      step();
      cfg_wr = 1'b1; cfg_rate = 2'(rate); cfg_ts0 = ts0;
   endtask

   // frames of 256 bits; a sync pulse every fs_every frames; one buffer rewrite mid-frame
   task automatic run_frames(int nframes, int fs_every, int ratio);
      for (int f = 0; f < nframes; f++) begin
         for (int c = 0; c < 256 * ratio; c++) begin
            step();
            if (c == 0 && f % fs_every == 0) begin ob_fs = 1'b1; ib_fs = 1'b1; end
            if (c == 44 * ratio) begin
               ob_wr = 1'b1; ob_slot = 5'd20; ob_data = 8'(8'h5A ^ (f * 17) ^ ratio);
            end
         end
      end
   endtask

   initial begin
      #(200000 * 10);
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #2;
      tag = "R1";
      chk("R1 reset dout_oe", dout_oe, 0);
      chk("R3 reset ib_valid", ib_valid, 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      run_cmp = 1'b1;
      for (int s = 0; s < 32; s++) begin
         step();
         ob_wr = 1'b1; ob_slot = 5'(s); ob_data = 8'((s * 37 + 8'h1D) & 8'hFF);
      end
      tag = "R1";
      run_frames(1, 1, 1);
      tag = "R4 excluded";
      configure(0, 1'b0);
      run_frames(2, 1, 1);
      tag = "R4 included";
      configure(0, 1'b1);
      run_frames(2, 1, 1);
      tag = "R5 x2";
      configure(1, 1'b1);
      run_frames(2, 1, 2);
      tag = "R5 x4";
      configure(2, 1'b0);
      run_frames(2, 1, 4);
      tag = "R5 x8";
      configure(3, 1'b1);
      run_frames(1, 1, 8);
      tag = "R8 every second frame";
      configure(0, 1'b1);
      odd_seen = 0; even_seen = 0;
      run_frames(4, 2, 1);
      checks++;
      if (odd_seen == 0 || even_seen == 0) begin
         errors++;
         $display("FAIL R8 parity: actual odd %0d even %0d expected both nonzero", odd_seen, even_seen);
      end
      tag = "R6 R7 realign";
      repeat (77) step();
      step(); ob_fs = 1'b1;
      repeat (133) step();
      step(); ib_fs = 1'b1;
      configure(2, 1'b0);
      repeat (301) step();
      step(); ob_fs = 1'b1; ib_fs = 1'b1;
      repeat (1100) step();
      repeat (3) step();
      run_cmp = 1'b0;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule